// File: doc/BRIEF.md
# Soft-Start Reference Ramp Sequencer

This block sequences the start-up of a switching regulator's control loop in the digital domain. When a start is requested it first holds the error amplifier in reset: a strobe output tells the analog side to tie the compensation node to the feedback node. It then produces a reference-clamp code that climbs linearly from zero to full scale. The code drives a DAC that limits the amplifier reference, so the output voltage rises at a controlled rate.

Each phase lasts a power-of-two number of clocks. At the default of 2048 clocks per phase and a 250 kHz clock, each phase takes about 8.2 ms. The block also gives the smaller of the ramp code and a nominal target code. That value is the effective reference: it follows the ramp until the ramp passes the target. Any rail whose reference tracks the main output needs no ramp of its own.

An abort returns the block to idle within one cycle and zeroes the ramp code. After a completed ramp the code stays at full scale until the next start or abort.

Top module: `ss_ramp_gen`

## Requirements
- R1: After reset, amp_rst_o, busy_o and done_o are low, and ramp_code_o and clamp_ref_o are zero.
- R2: A start_i sampled high while busy_o is low puts the block into the amplifier-reset phase from the next cycle. In that phase amp_rst_o is high for exactly 2^RST_LOG2 consecutive cycles.
- R3: In ramp cycle m, counted from 0 starting right after the reset phase, ramp_code_o equals floor(m / 2^(RAMP_LOG2-CODE_W)). The code never falls and rises by at most one LSB per cycle. The ramp phase lasts 2^RAMP_LOG2 cycles.
- R4: After the ramp phase ends, ramp_code_o holds at all ones until a start or an abort is accepted.
- R5: done_o is a one-cycle pulse in the first cycle after the ramp phase. busy_o is high from the cycle after an accepted start through the last ramp cycle, and low at all other times.
- R6: clamp_ref_o always equals the smaller of ramp_code_o and target_i.
- R7: A cycle with abort_i high leaves the block idle in the next cycle: amp_rst_o, busy_o and done_o are low and ramp_code_o is zero. Abort takes priority over a start in the same cycle.
- R8: start_i has no effect while busy_o is high. The phase and the ramp code continue unchanged.
- R9: While amp_rst_o is high, busy_o is high and ramp_code_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock (nominally the switching clock) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, one cycle or longer |
| abort_i | input | 1 | Return to idle and zero the ramp |
| target_i | input | CODE_W | Nominal reference code |
| amp_rst_o | output | 1 | Error-amplifier reset strobe (comp-to-fb short) |
| ramp_code_o | output | CODE_W | Soft-start ramp code |
| clamp_ref_o | output | CODE_W | Effective reference, min of ramp and target |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the ramp ends |

## Verification
The bench counts the exact length of the reset strobe. A design off by one at the phase boundary would cut the reset short, stretch it, or start the ramp one step early. Every ramp cycle is compared against the computed staircase, so a wrong counter slice or a skipped step shows up as a miscompare at the exact ramp cycle. Aborts are tested in both phases and together with a start in the same cycle: a design that let the start win, or delayed the clear, would show busy or a non-zero code in the following cycle. A start issued mid-ramp must leave the staircase untouched. A small target must cap the effective reference, while the raw code still reaches full scale.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [1:0] {
    SS_IDLE    = 2'd0,
    SS_AMP_RST = 2'd1,
    SS_RAMP    = 2'd2,
    SS_HOLD    = 2'd3
  } ss_state_e;
endpackage

// File: rtl/ss_seq_ctrl.sv
module ss_seq_ctrl
  import ss_pkg::*;
#(
  parameter int RST_LOG2  = 11,
  parameter int RAMP_LOG2 = 11,
  parameter int CNT_W     = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [CNT_W-1:0] cnt_i,
  output ss_state_e        state_o,
  output logic             cnt_clr_o,
  output logic             cnt_en_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] RstLast  = CNT_W'((64'd1 << RST_LOG2) - 64'd1);
  localparam logic [CNT_W-1:0] RampLast = CNT_W'((64'd1 << RAMP_LOG2) - 64'd1);

  ss_state_e state_q, state_d;
  logic      done_q;
  logic      busy, go, rst_end, ramp_end;

  assign busy     = (state_q == SS_AMP_RST) || (state_q == SS_RAMP);
  assign go       = start_i && !abort_i && !busy;
  assign rst_end  = (state_q == SS_AMP_RST) && (cnt_i == RstLast);
  assign ramp_end = (state_q == SS_RAMP) && (cnt_i == RampLast);

  always_comb begin
    state_d = state_q;
    if (abort_i) begin
      state_d = SS_IDLE;
    end else begin
      unique case (state_q)
        SS_IDLE, SS_HOLD: if (go) state_d = SS_AMP_RST;
        SS_AMP_RST:       if (rst_end) state_d = SS_RAMP;
        SS_RAMP:          if (ramp_end) state_d = SS_HOLD;
        default:          state_d = SS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SS_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= ramp_end && !abort_i;
    end
  end

  assign state_o   = state_q;
  assign cnt_clr_o = go || rst_end || ramp_end || abort_i;
  assign cnt_en_o  = busy;
  assign done_o    = done_q;
endmodule

// File: rtl/ss_phase_cnt.sv
module ss_phase_cnt #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ss_code_map.sv
module ss_code_map
  import ss_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  ss_state_e         state_i,
  input  logic [CODE_W-1:0] step_i,
  output logic [CODE_W-1:0] code_o
);
  always_comb begin
    unique case (state_i)
      SS_RAMP: code_o = step_i;
      SS_HOLD: code_o = '1;
      default: code_o = '0;
    endcase
  end
endmodule

// File: rtl/ss_ref_clamp.sv
module ss_ref_clamp #(
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0] ramp_i,
  input  logic [CODE_W-1:0] target_i,
  output logic [CODE_W-1:0] ref_o
);
  assign ref_o = (ramp_i < target_i) ? ramp_i : target_i;
endmodule

// File: rtl/ss_ramp_gen.sv
module ss_ramp_gen
  import ss_pkg::*;
#(
  parameter int RST_LOG2  = 11,
  parameter int RAMP_LOG2 = 11,
  parameter int CODE_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [CODE_W-1:0] target_i,
  output logic              amp_rst_o,
  output logic [CODE_W-1:0] ramp_code_o,
  output logic [CODE_W-1:0] clamp_ref_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int CNT_W = (RST_LOG2 > RAMP_LOG2) ? RST_LOG2 : RAMP_LOG2;

  ss_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic             cnt_clr, cnt_en;
  logic [CODE_W-1:0] step;

  ss_seq_ctrl #(
    .RST_LOG2 (RST_LOG2),
    .RAMP_LOG2(RAMP_LOG2),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .abort_i  (abort_i),
    .cnt_i    (cnt),
    .state_o  (state),
    .cnt_clr_o(cnt_clr),
    .cnt_en_o (cnt_en),
    .done_o   (done_o)
  );

  ss_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .en_i  (cnt_en),
    .cnt_o (cnt)
  );

  // ramp step = top CODE_W bits of the ramp-phase count
  assign step = cnt[RAMP_LOG2-1 -: CODE_W];

  ss_code_map #(.CODE_W(CODE_W)) u_map (
    .state_i(state),
    .step_i (step),
    .code_o (ramp_code_o)
  );

  ss_ref_clamp #(.CODE_W(CODE_W)) u_clamp (
    .ramp_i  (ramp_code_o),
    .target_i(target_i),
    .ref_o   (clamp_ref_o)
  );

  assign amp_rst_o = (state == SS_AMP_RST);
  assign busy_o    = (state == SS_AMP_RST) || (state == SS_RAMP);
endmodule

// File: rtl/ss_ramp_gen_chk.sv
module ss_ramp_gen_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              abort_i,
  input logic [CODE_W-1:0] target_i,
  input logic              amp_rst_o,
  input logic [CODE_W-1:0] ramp_code_o,
  input logic [CODE_W-1:0] clamp_ref_o,
  input logic              busy_o,
  input logic              done_o
);
  a_r7_abort_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_o && !amp_rst_o && !done_o && ramp_code_o == '0));

  a_r3_no_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !abort_i) |=> (ramp_code_o >= $past(ramp_code_o)));

  a_r3_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !abort_i) |=> ((ramp_code_o - $past(ramp_code_o)) <= CODE_W'(1)));

  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r5_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(busy_o) && !busy_o));

  a_r4_hold_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && ramp_code_o == '1 && !start_i && !abort_i) |=> (ramp_code_o == '1));

  a_r9_rst_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_rst_o |-> (busy_o && ramp_code_o == '0));

  a_r6_clamp_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clamp_ref_o <= target_i) && (clamp_ref_o <= ramp_code_o));
endmodule

bind ss_ramp_gen ss_ramp_gen_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .abort_i    (abort_i),
  .target_i   (target_i),
  .amp_rst_o  (amp_rst_o),
  .ramp_code_o(ramp_code_o),
  .clamp_ref_o(clamp_ref_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/ss_ramp_gen_tb.sv
module ss_ramp_gen_tb;
  localparam int RST_LOG2  = 11;
  localparam int RAMP_LOG2 = 11;
  localparam int CODE_W    = 8;
  localparam int RST_N     = 1 << RST_LOG2;
  localparam int RAMP_N    = 1 << RAMP_LOG2;
  localparam int SHIFT     = RAMP_LOG2 - CODE_W;
  localparam int FULL      = (1 << CODE_W) - 1;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic              abort_i = 1'b0;
  logic [CODE_W-1:0] target_i = '1;
  logic              amp_rst_o, busy_o, done_o;
  logic [CODE_W-1:0] ramp_code_o, clamp_ref_o;

  int vectors = 0;
  int errors  = 0;

  always #10 clk = ~clk;

  ss_ramp_gen #(.RST_LOG2(RST_LOG2), .RAMP_LOG2(RAMP_LOG2), .CODE_W(CODE_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .abort_i(abort_i),
    .target_i(target_i), .amp_rst_o(amp_rst_o), .ramp_code_o(ramp_code_o),
    .clamp_ref_o(clamp_ref_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // pulse for one cycle; returns at the negedge after the sampling edge
  task automatic pulse(input bit s, input bit a);
    @(negedge clk);
    start_i = s;
    abort_i = a;
    @(negedge clk);
    start_i = 1'b0;
    abort_i = 1'b0;
  endtask

  task automatic chk_idle(input string req, input int code);
    chk(req, "amp_rst", int'(amp_rst_o), 0);
    chk(req, "busy", int'(busy_o), 0);
    chk(req, "done", int'(done_o), 0);
    chk(req, "code", int'(ramp_code_o), code);
  endtask

  // runs the whole sequence after a start pulse, checking every cycle
  task automatic run_full(input string tag);
    int tgt;
    tgt = int'(target_i);
    for (int i = 0; i < RST_N; i++) begin
      chk("R2", "amp_rst", int'(amp_rst_o), 1);
      chk("R9", "code in reset", int'(ramp_code_o), 0);
      chk("R5", "busy in reset", int'(busy_o), 1);
      @(negedge clk);
    end
    for (int m = 0; m < RAMP_N; m++) begin
      chk("R2", "amp_rst in ramp", int'(amp_rst_o), 0);
      chk("R3", "ramp code", int'(ramp_code_o), m >> SHIFT);
      chk("R6", "clamp", int'(clamp_ref_o), min2(m >> SHIFT, tgt));
      chk("R5", "busy in ramp", int'(busy_o), 1);
      chk("R5", "done early", int'(done_o), 0);
      @(negedge clk);
    end
    chk("R5", "done pulse", int'(done_o), 1);
    chk("R5", "busy after ramp", int'(busy_o), 0);
    chk("R4", "full scale", int'(ramp_code_o), FULL);
    chk("R6", "clamp at end", int'(clamp_ref_o), min2(FULL, tgt));
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk("R5", "done width", int'(done_o), 0);
      chk("R4", "hold", int'(ramp_code_o), FULL);
    end
    $display("scenario %s done", tag);
  endtask

  task automatic t_reset_state();
    chk_idle("R1", 0);
    chk("R1", "clamp", int'(clamp_ref_o), 0);
  endtask

  task automatic t_full_nominal();
    target_i = 8'd200;
    pulse(1'b1, 1'b0);
    run_full("full_nominal");
  endtask

  task automatic t_restart_small_target();
    target_i = 8'd100;
    pulse(1'b1, 1'b0);
    run_full("restart_small_target");
  endtask

  task automatic t_abort_in_reset();
    pulse(1'b1, 1'b0);
    repeat (100) @(negedge clk);
    chk("R2", "amp_rst before abort", int'(amp_rst_o), 1);
    pulse(1'b0, 1'b1);
    chk_idle("R7", 0);
    repeat (RST_N) @(negedge clk);
    chk_idle("R7", 0);
  endtask

  task automatic t_abort_in_ramp();
    pulse(1'b1, 1'b0);
    repeat (RST_N + 800) @(negedge clk);
    chk("R3", "code before abort", int'(ramp_code_o), 800 >> SHIFT);
    pulse(1'b0, 1'b1);
    chk_idle("R7", 0);
    repeat (RAMP_N) @(negedge clk);
    chk_idle("R7", 0);
  endtask

  task automatic t_abort_over_start();
    pulse(1'b1, 1'b1);
    chk_idle("R7", 0);
    repeat (5) @(negedge clk);
    chk_idle("R7", 0);
  endtask

  task automatic t_abort_from_hold();
    pulse(1'b1, 1'b0);
    repeat (RST_N + RAMP_N + 3) @(negedge clk);
    chk("R4", "hold before abort", int'(ramp_code_o), FULL);
    pulse(1'b0, 1'b1);
    chk_idle("R7", 0);
  endtask

  task automatic t_start_while_busy();
    pulse(1'b1, 1'b0);
    repeat (RST_N + 500) @(negedge clk);
    pulse(1'b1, 1'b0);
    // 502 ramp cycles have now elapsed
    chk("R8", "code after mid start", int'(ramp_code_o), 502 >> SHIFT);
    chk("R8", "amp_rst after mid start", int'(amp_rst_o), 0);
    repeat (RAMP_N - 502) @(negedge clk);
    chk("R8", "done on time", int'(done_o), 1);
    chk("R8", "code full", int'(ramp_code_o), FULL);
    pulse(1'b0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    vectors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_full_nominal();
    t_restart_small_target();
    t_abort_in_reset();
    t_abort_in_ramp();
    t_abort_over_start();
    t_abort_from_hold();
    t_start_while_busy();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule